// File: doc/BRIEF.md
# Integer Execution Unit with Barrel Shifter

This block is the integer datapath of a 32-bit load/store processor. Each cycle it takes one instruction word and the two source operand values read from the register file. It works out the operation from the instruction's primary opcode or, for register-register instructions, from its function field. It then computes the arithmetic, logical, comparison, upper-immediate or shift result. The result is registered together with the index of the destination register it belongs to, so the writeback stage sees it one clock later.

Register-register instructions write the register named by the rd field. Immediate instructions write the register named by the rt field. The unit decides per opcode whether the 16-bit immediate is sign-extended or zero-extended. Add and subtract wrap modulo 2^32 and never trap, so the signed and unsigned forms of each behave the same. Shifts take their distance either from the shamt field of the instruction or from the low five bits of the rs operand. An encoding the unit does not implement yields a zero result and raises a flag, so the surrounding pipeline can treat it as an illegal instruction.

Top module: `exu_alu`

## Requirements
- R1: While rst_n is low, result, dst_reg and illegal are all zero, regardless of the instruction presented.
- R2: With primary opcode (bits 31:26) 000000, function field (bits 5:0) 100000 and 100001 both give rs_val + rt_val modulo 2^32, with illegal low, including when the signed sum overflows.
- R3: Function codes 100010 and 100011 both give rs_val - rt_val modulo 2^32, with no trap.
- R4: Function codes 100100, 100101, 100110 and 100111 give bitwise AND, OR, XOR and NOR of rs_val and rt_val.
- R5: Function code 101010 gives 1 when rs_val < rt_val as signed numbers, else 0. Function code 101011 makes the same comparison unsigned.
- R6: Primary opcodes 001000 and 001001 add the sign-extended 16-bit immediate (bits 15:0) to rs_val. Opcode 001010 compares rs_val against the sign-extended immediate as signed numbers. Opcode 001011 sign-extends the immediate and then compares unsigned.
- R7: Primary opcodes 001100, 001101 and 001110 AND, OR and XOR rs_val with the immediate zero-extended to 32 bits.
- R8: Primary opcode 001111 gives the immediate in bits 31:16 and zeros in bits 15:0, ignoring rs_val.
- R9: Function codes 000000, 000010 and 000011 shift rt_val left logically, right logically and right arithmetically by the shamt field (bits 10:6).
- R10: Function codes 000100, 000110 and 000111 perform the same three shifts by rs_val[4:0]. The upper bits of rs_val and the shamt field have no effect.
- R11: dst_reg is the rd field (bits 15:11) for register-register instructions and the rt field (bits 20:16) for immediate instructions.
- R12: Any other primary opcode or function code gives result 0, dst_reg 0 and illegal 1.
- R13: The outputs reflect the instruction and operands present at the preceding rising clock edge and stay unchanged between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 32 | Instruction word being executed |
| rs_val | input | 32 | Value of the rs source register |
| rt_val | input | 32 | Value of the rt source register |
| result | output | 32 | Registered result of the operation |
| dst_reg | output | 5 | Registered destination register index |
| illegal | output | 1 | Registered flag for an unimplemented encoding |

## Verification
The cases hardest to reach from the ports are those where a field the operation must ignore carries live data. Examples are a variable shift whose rs operand has set bits above bit 4 and a nonzero shamt field, an upper-immediate load with all-ones rs_val, and an unsigned immediate compare whose immediate has its top bit set. The vector table fills those ignored fields deliberately, so that a decoder mixing up the shift source or the extension mode gives a wrong result. The bench also uses operand pairs at the signed overflow boundary and at shift distances 0, 1 and 31.

// File: rtl/exu_pkg.sv
package exu_pkg;

    typedef enum logic [3:0] {
        OP_ADD,
        OP_SUB,
        OP_AND,
        OP_OR,
        OP_XOR,
        OP_NOR,
        OP_SLT,
        OP_SLTU,
        OP_LUI,
        OP_SLL,
        OP_SRL,
        OP_SRA,
        OP_BAD
    } alu_op_e;

    typedef struct packed {
        alu_op_e op;
        logic    use_imm;    // second operand is the immediate
        logic    imm_zext;   // zero-extend instead of sign-extend
        logic    var_shamt;  // shift distance from rs operand
        logic    to_rt;      // destination is the rt field
        logic    bad;        // unimplemented encoding
    } dec_t;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output dec_t       dec
);

    always_comb begin
        dec = '{op: OP_BAD, use_imm: 1'b0, imm_zext: 1'b0,
                var_shamt: 1'b0, to_rt: 1'b0, bad: 1'b0};
        if (opcode == 6'b000000) begin
            unique case (funct)
                6'b100000, 6'b100001: dec.op = OP_ADD;
                6'b100010, 6'b100011: dec.op = OP_SUB;
                6'b100100: dec.op = OP_AND;
                6'b100101: dec.op = OP_OR;
                6'b100110: dec.op = OP_XOR;
                6'b100111: dec.op = OP_NOR;
                6'b101010: dec.op = OP_SLT;
                6'b101011: dec.op = OP_SLTU;
                6'b000000: dec.op = OP_SLL;
                6'b000010: dec.op = OP_SRL;
                6'b000011: dec.op = OP_SRA;
                6'b000100: begin dec.op = OP_SLL; dec.var_shamt = 1'b1; end
                6'b000110: begin dec.op = OP_SRL; dec.var_shamt = 1'b1; end
                6'b000111: begin dec.op = OP_SRA; dec.var_shamt = 1'b1; end
                default:   dec.bad = 1'b1;
            endcase
        end else begin
            dec.use_imm = 1'b1;
            dec.to_rt   = 1'b1;
            unique case (opcode)
                6'b001000, 6'b001001: dec.op = OP_ADD;
                6'b001010: dec.op = OP_SLT;
                6'b001011: dec.op = OP_SLTU;
                6'b001100: begin dec.op = OP_AND; dec.imm_zext = 1'b1; end
                6'b001101: begin dec.op = OP_OR;  dec.imm_zext = 1'b1; end
                6'b001110: begin dec.op = OP_XOR; dec.imm_zext = 1'b1; end
                6'b001111: dec.op = OP_LUI;
                default:   dec.bad = 1'b1;
            endcase
        end
        if (dec.bad) begin
            dec.op = OP_BAD;
        end
    end

endmodule

// File: rtl/exu_shift.sv
module exu_shift #(
    parameter int W = 32,
    localparam int SB = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SB-1:0] amt,
    input  logic          left,
    input  logic          arith,
    output logic [W-1:0]  dout
);

    // One right-shift network; left shifts reverse the word on the way in and out.
    logic          fill;
    logic [W-1:0]  pre;
    logic [W-1:0]  post;
    logic [W-1:0]  stg [SB+1];

    always_comb begin
        fill = arith & ~left & din[W-1];
        for (int i = 0; i < W; i++) begin
            pre[i] = left ? din[W-1-i] : din[i];
        end
    end

    assign stg[0] = pre;

    for (genvar k = 0; k < SB; k++) begin : g_stage
        localparam int D = 1 << k;
        assign stg[k+1] = amt[k] ? {{D{fill}}, stg[k][W-1:D]} : stg[k];
    end

    assign post = stg[SB];

    always_comb begin
        for (int i = 0; i < W; i++) begin
            dout[i] = left ? post[W-1-i] : post[i];
        end
    end

endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int IMMW = 16,
    localparam int SHW  = $clog2(XLEN),
    localparam int REGW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic [XLEN-1:0] result,
    output logic [REGW-1:0] dst_reg,
    output logic            illegal
);

    typedef struct packed {
        logic [XLEN-1:0] res;
        logic [REGW-1:0] dst;
        logic            bad;
    } stage_t;

    stage_t stage_d, stage_q;

    dec_t            dec;
    logic [IMMW-1:0] imm;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] opb;
    logic [SHW-1:0]  shamt;
    logic [XLEN-1:0] shifted;
    logic            unused_fields;

    assign imm           = instr[IMMW-1:0];
    assign unused_fields = ^instr[25:21];

    exu_decode u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .dec    (dec)
    );

    assign imm_ext = dec.imm_zext ? {{(XLEN-IMMW){1'b0}}, imm}
                                  : {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
    assign opb     = dec.use_imm ? imm_ext : rt_val;
    assign shamt   = dec.var_shamt ? rs_val[SHW-1:0] : instr[6+SHW-1:6];

    exu_shift #(.W(XLEN)) u_shift (
        .din   (rt_val),
        .amt   (shamt),
        .left  (dec.op == OP_SLL),
        .arith (dec.op == OP_SRA),
        .dout  (shifted)
    );

    always_comb begin
        stage_d     = '0;
        stage_d.bad = dec.bad;
        stage_d.dst = dec.bad ? '0 : (dec.to_rt ? instr[20:16] : instr[15:11]);
        unique case (dec.op)
            OP_ADD:  stage_d.res = rs_val + opb;
            OP_SUB:  stage_d.res = rs_val - opb;
            OP_AND:  stage_d.res = rs_val & opb;
            OP_OR:   stage_d.res = rs_val | opb;
            OP_XOR:  stage_d.res = rs_val ^ opb;
            OP_NOR:  stage_d.res = ~(rs_val | opb);
            OP_SLT:  stage_d.res = {{(XLEN-1){1'b0}}, $signed(rs_val) < $signed(opb)};
            OP_SLTU: stage_d.res = {{(XLEN-1){1'b0}}, rs_val < opb};
            OP_LUI:  stage_d.res = {imm, {(XLEN-IMMW){1'b0}}};
            OP_SLL, OP_SRL, OP_SRA: stage_d.res = shifted;
            default: stage_d.res = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign result  = stage_q.res;
    assign dst_reg = stage_q.dst;
    assign illegal = stage_q.bad;

    // Checks: primed_q marks that one edge has passed since reset.
    logic primed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    assert_bad_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (result == '0 && dst_reg == '0));

    assert_add_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(instr[31:26] == 6'b000000 && instr[5:1] == 5'b10000))
        |-> (result == $past(rs_val + rt_val) && !illegal));

    assert_lui_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(instr[31:26] == 6'b001111))
        |-> (result == {$past(instr[15:0]), {(XLEN-IMMW){1'b0}}}));

    assert_slt_bool_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(instr[31:26] == 6'b000000 && instr[5:1] == 5'b10101))
        |-> (result[XLEN-1:1] == '0));

    assert_imm_dst_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !illegal && $past(instr[31:26] != 6'b000000))
        |-> (dst_reg == $past(instr[20:16])));

endmodule

// File: tb/exu_alu_test.sv
module exu_alu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] result;
    logic [4:0]  dst_reg;
    logic        illegal;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    exu_alu uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .instr   (instr),
        .rs_val  (rs_val),
        .rt_val  (rt_val),
        .result  (result),
        .dst_reg (dst_reg),
        .illegal (illegal)
    );

    localparam int NV = 29;

    localparam logic [31:0] V_INSTR [NV] = '{
        {6'h00, 5'd1, 5'd2, 5'd5,  5'd0,  6'b100000},  // R2 ADD overflow
        {6'h00, 5'd1, 5'd2, 5'd6,  5'd0,  6'b100001},  // R2 ADDU wrap
        {6'h00, 5'd1, 5'd2, 5'd7,  5'd0,  6'b100010},  // R3 SUB
        {6'h00, 5'd1, 5'd2, 5'd8,  5'd0,  6'b100011},  // R3 SUBU
        {6'h00, 5'd1, 5'd2, 5'd9,  5'd0,  6'b100100},  // R4 AND
        {6'h00, 5'd1, 5'd2, 5'd10, 5'd0,  6'b100101},  // R4 OR
        {6'h00, 5'd1, 5'd2, 5'd11, 5'd0,  6'b100110},  // R4 XOR
        {6'h00, 5'd1, 5'd2, 5'd12, 5'd0,  6'b100111},  // R4 NOR
        {6'h00, 5'd1, 5'd2, 5'd13, 5'd0,  6'b101010},  // R5 SLT
        {6'h00, 5'd1, 5'd2, 5'd14, 5'd0,  6'b101011},  // R5 SLTU
        {6'b001000, 5'd1, 5'd3,  16'hFFFF},            // R6 ADDI
        {6'b001001, 5'd1, 5'd4,  16'h8000},            // R6 ADDIU
        {6'b001010, 5'd1, 5'd17, 16'hFFFF},            // R6 SLTI
        {6'b001011, 5'd1, 5'd18, 16'hFFFF},            // R6 SLTIU high imm
        {6'b001011, 5'd1, 5'd19, 16'h0004},            // R6 SLTIU false
        {6'b001100, 5'd1, 5'd20, 16'h8F0F},            // R7 ANDI
        {6'b001101, 5'd1, 5'd21, 16'h8000},            // R7 ORI
        {6'b001110, 5'd1, 5'd22, 16'hFFFF},            // R7 XORI
        {6'b001111, 5'd1, 5'd23, 16'hABCD},            // R8 LUI
        {6'h00, 5'd0, 5'd2, 5'd24, 5'd4,  6'b000000},  // R9 SLL 4
        {6'h00, 5'd0, 5'd2, 5'd25, 5'd8,  6'b000010},  // R9 SRL 8
        {6'h00, 5'd0, 5'd2, 5'd26, 5'd8,  6'b000011},  // R9 SRA 8
        {6'h00, 5'd0, 5'd2, 5'd27, 5'd31, 6'b000011},  // R9 SRA 31
        {6'h00, 5'd1, 5'd2, 5'd28, 5'd0,  6'b000100},  // R10 SLLV
        {6'h00, 5'd1, 5'd2, 5'd29, 5'd0,  6'b000110},  // R10 SRLV 0
        {6'h00, 5'd1, 5'd2, 5'd30, 5'd3,  6'b000111},  // R10 SRAV 31, sa ignored
        {6'h00, 5'd1, 5'd2, 5'd31, 5'd0,  6'b001000},  // R12 unknown funct
        {6'b100011, 5'd1, 5'd9, 16'h0010},             // R12 unknown opcode
        {6'h00, 5'd1, 5'd2, 5'd15, 5'd0,  6'b101100}   // R12 unknown funct
    };

    localparam logic [31:0] V_RS [NV] = '{
        32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0005, 32'h8000_0000,
        32'hF0F0_F0F0, 32'hF0F0_F0F0, 32'hF0F0_F0F0, 32'hF0F0_F0F0,
        32'hFFFF_FFFF, 32'hFFFF_FFFF,
        32'h0000_000A, 32'h0000_0000, 32'hFFFF_FFFE, 32'h0000_0005,
        32'h0000_0005, 32'hFFFF_FFFF, 32'h1234_0000, 32'hFFFF_0000,
        32'hFFFF_FFFF,
        32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
        32'hFFFF_FFE1, 32'h0000_0020, 32'h0000_001F,
        32'h0000_0001, 32'h0000_0001, 32'h0000_0001
    };

    localparam logic [31:0] V_RT [NV] = '{
        32'h0000_0001, 32'h0000_0002, 32'h0000_0007, 32'h0000_0001,
        32'hFF00_FF00, 32'hFF00_FF00, 32'hFF00_FF00, 32'hFF00_FF00,
        32'h0000_0001, 32'h0000_0001,
        32'h5555_5555, 32'h5555_5555, 32'h5555_5555, 32'h5555_5555,
        32'h5555_5555, 32'h5555_5555, 32'h5555_5555, 32'h5555_5555,
        32'h5555_5555,
        32'h8765_4321, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000,
        32'h8000_0001, 32'hDEAD_BEEF, 32'h4000_0000,
        32'h0000_0001, 32'h0000_0001, 32'h0000_0001
    };

    localparam logic [31:0] V_RES [NV] = '{
        32'h8000_0000, 32'h0000_0001, 32'hFFFF_FFFE, 32'h7FFF_FFFF,
        32'hF000_F000, 32'hFFF0_FFF0, 32'h0FF0_0FF0, 32'h000F_000F,
        32'h0000_0001, 32'h0000_0000,
        32'h0000_0009, 32'hFFFF_8000, 32'h0000_0001, 32'h0000_0001,
        32'h0000_0000, 32'h0000_8F0F, 32'h1234_8000, 32'hFFFF_FFFF,
        32'hABCD_0000,
        32'h7654_3210, 32'h0080_0000, 32'hFF80_0000, 32'hFFFF_FFFF,
        32'h0000_0002, 32'hDEAD_BEEF, 32'h0000_0000,
        32'h0000_0000, 32'h0000_0000, 32'h0000_0000
    };

    localparam logic [4:0] V_DST [NV] = '{
        5'd5, 5'd6, 5'd7, 5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13, 5'd14,
        5'd3, 5'd4, 5'd17, 5'd18, 5'd19, 5'd20, 5'd21, 5'd22, 5'd23,
        5'd24, 5'd25, 5'd26, 5'd27, 5'd28, 5'd29, 5'd30,
        5'd0, 5'd0, 5'd0
    };

    localparam logic V_ILL [NV] = '{
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b1, 1'b1, 1'b1
    };

    task automatic check(input string req, input logic [31:0] exp_res,
                         input logic [4:0] exp_dst, input logic exp_ill);
        n_run++;
        if (result !== exp_res || dst_reg !== exp_dst || illegal !== exp_ill) begin
            n_fail++;
            $display("FAIL %s: result=%h dst=%0d illegal=%b, expected result=%h dst=%0d illegal=%b",
                     req, result, dst_reg, illegal, exp_res, exp_dst, exp_ill);
        end
    endtask

    task automatic apply(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        instr  = i;
        rs_val = a;
        rt_val = b;
    endtask

    initial begin
        // R1: reset holds outputs at zero even with a live instruction
        instr  = {6'b001111, 5'd1, 5'd23, 16'hABCD};
        rs_val = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R1 during reset", 32'h0, 5'd0, 1'b0);
        rst_n = 1'b1;

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            apply(V_INSTR[v], V_RS[v], V_RT[v]);
            @(negedge clk);
            check($sformatf("vector %0d (R2..R12)", v), V_RES[v], V_DST[v], V_ILL[v]);
        end

        // R13: new inputs do not show before the next rising edge
        apply(V_INSTR[4], V_RS[4], V_RT[4]);
        @(negedge clk);
        apply(V_INSTR[5], V_RS[5], V_RT[5]);
        #1;
        check("R13 hold before edge", V_RES[4], V_DST[4], V_ILL[4]);
        @(negedge clk);
        check("R13 update after edge", V_RES[5], V_DST[5], V_ILL[5]);

        // R12: illegal clears once a legal encoding follows
        apply(V_INSTR[27], V_RS[27], V_RT[27]);
        @(negedge clk);
        check("R12 illegal opcode", 32'h0, 5'd0, 1'b1);
        apply(V_INSTR[0], V_RS[0], V_RT[0]);
        @(negedge clk);
        check("R12 legal after illegal", V_RES[0], V_DST[0], 1'b0);

        // R10: upper rs bits ignored for variable left shift by 0
        apply({6'h00, 5'd1, 5'd2, 5'd16, 5'd7, 6'b000100}, 32'hFFFF_FFE0, 32'h1234_5678);
        @(negedge clk);
        check("R10 SLLV upper rs bits ignored", 32'h1234_5678, 5'd16, 1'b0);

        // R9: SLL by 31 and SRL by 1
        apply({6'h00, 5'd0, 5'd2, 5'd1, 5'd31, 6'b000000}, 32'h0, 32'h0000_0003);
        @(negedge clk);
        check("R9 SLL 31", 32'h8000_0000, 5'd1, 1'b0);
        apply({6'h00, 5'd0, 5'd2, 5'd2, 5'd1, 6'b000010}, 32'h0, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R9 SRL 1", 32'h7FFF_FFFF, 5'd2, 1'b0);

        // R1: asynchronous reset mid-run clears registered outputs
        apply(V_INSTR[17], V_RS[17], V_RT[17]);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 async reset", 32'h0, 5'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule